// File: doc/BRIEF.md
# Separable Input-First Switch Allocator

This block chooses, every clock cycle, which input virtual channels of a network-on-chip router may move a flit through the crossbar. The router has `NUM_PORTS` input ports, `NUM_PORTS` output ports and `NUM_VCS` virtual channels on each input. Each virtual channel presents a request that gives its target output port, whether it already owns a downstream output VC, whether it holds a credit for that VC, a tail marker and an arrival timestamp. The block does not store flits, move data, keep credit counts or manage a free-VC list. Those functions connect to it only through its ports.

Allocation runs in two stages and settles within the same cycle. First, each input port chooses one of its eligible VCs with a rotating priority. That choice becomes a bid for the output port the VC names. Second, each output port chooses one of the bidding inputs with its own rotating priority. For every winner the block drives the crossbar select, a one-cycle grant pulse to the winning input VC, a credit return toward the upstream router (marked as freeing the VC when the flit is a tail), and a request for a downstream output VC when the winner does not own one yet. An optional ordering mode blocks a VC from bidding while an older VC on the same input waits for the same output.

The priority pointers are the only state. An input pointer moves only when that input bids. An output pointer moves only when that output grants.

Top module: `sa_switch_alloc`

## Requirements
- R1: Reset sets every input pointer and every output pointer to index 0. With no valid request, `gnt_valid`, `vc_gnt`, `ovc_alloc_req`, `credit_ret` and `credit_free` are all zero.
- R2: Request index k = i*NUM_VCS + v selects input i, VC v. VC k is eligible only if all of the following hold: `req_valid[k]` is 1; when `req_has_ovc[k]` is 1, `req_credit_ok[k]` is 1; when `req_has_ovc[k]` is 0, `out_free_vc` at its target port is 1.
- R3: Each input bids with the first eligible VC found by searching upward from its pointer, wrapping at NUM_VCS. After a bid the pointer becomes the bid VC plus 1, and NUM_VCS wraps to 0. An input that places no bid keeps its pointer.
- R4: Each output grants the first bidding input found by searching upward from its pointer, wrapping at NUM_PORTS. After a grant the pointer becomes the granted input plus 1, wrapped. An output that grants nothing keeps its pointer.
- R5: In one cycle, each input has at most one VC granted and is granted by at most one output.
- R6: While `order_en` is 1, VC k is not eligible if another valid VC on the same input targets the same port with a strictly smaller unsigned `req_ts`. Equal timestamps block neither VC.
- R7: `ovc_alloc_req[o]` is 1 exactly when output o grants a VC whose `req_has_ovc` is 0.
- R8: `credit_ret[k]` pulses together with `vc_gnt[k]`. `credit_free[k]` is 1 when `vc_gnt[k]` is 1 and `req_tail[k]` is 1, and is 0 otherwise.
- R9: For output o, `gnt_in[o*PW +: PW]` is the granted input and `gnt_vc[o*VW +: VW]` is its VC. Both read zero while `gnt_valid[o]` is 0. `req_port` and `req_ts` hold field k at `k*PW` and `k*TS_W`.
- R10: If a single input's VCs all request one output that no other input requests, each of those VCs is granted within NUM_VCS cycles. If one VC on every input requests the same output, each input is granted within NUM_PORTS cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| order_en | input | 1 | Enables oldest-first ordering per input and output |
| req_valid | input | NV | VC waiting for switch allocation |
| req_port | input | NV*PW | Target output port of each VC |
| req_has_ovc | input | NV | VC already owns a downstream output VC |
| req_credit_ok | input | NV | VC holds at least one credit for its output VC |
| req_tail | input | NV | Head flit of the VC is a tail or single-flit packet |
| req_ts | input | NV*TS_W | Enqueue timestamp of the head flit |
| out_free_vc | input | NUM_PORTS | Output has at least one free downstream VC |
| gnt_valid | output | NUM_PORTS | Output grants this cycle |
| gnt_in | output | NUM_PORTS*PW | Crossbar select: granted input per output |
| gnt_vc | output | NUM_PORTS*VW | Granted VC index per output |
| vc_gnt | output | NV | Grant pulse per input VC |
| ovc_alloc_req | output | NUM_PORTS | Request to allocate an output VC for the winner |
| credit_ret | output | NV | Credit returned upstream for the granted VC |
| credit_free | output | NV | Credit also frees the VC (tail departure) |

## Verification
The assertions assume that the request inputs are stable around the sampling edge and that `req_port` only names existing ports. With the default power-of-two port count every encoding is legal, and the bench drives inputs only at the falling edge. The ordering property assumes timestamps do not wrap. The bench therefore draws timestamps from a small range and compares them as plain unsigned values. It also uses few distinct values, so equal and unequal timestamps both occur often.

// File: rtl/sa_pkg.sv
package sa_pkg;

    // Rotating pointer increment: returns idx+1, or 0 once the limit is reached.
    function automatic int wrap_inc(input int idx, input int lim);
        return (idx + 1 >= lim) ? 0 : idx + 1;
    endfunction

endpackage

// File: rtl/sa_rr_pick.sv
// Rotating-priority picker: first set bit at or after ptr, wrapping.
module sa_rr_pick #(
    parameter int W  = 4,
    localparam int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  req,
    input  logic [IW-1:0] ptr,
    output logic          found,
    output logic [IW-1:0] idx
);
    int c;
    always_comb begin
        found = 1'b0;
        idx   = '0;
        c     = 0;
        for (int j = 0; j < W; j++) begin
            c = int'(ptr) + j;
            if (c >= W) c = c - W;
            if (!found && req[c]) begin
                found = 1'b1;
                idx   = IW'(c);
            end
        end
    end
endmodule

// File: rtl/sa_vc_filter.sv
// Per-input eligibility: credit / free-VC rule plus optional age ordering.
module sa_vc_filter #(
    parameter int NUM_PORTS = 4,
    parameter int NUM_VCS   = 4,
    parameter int TS_W      = 8,
    localparam int PW = $clog2(NUM_PORTS)
) (
    input  logic                      order_en,
    input  logic [NUM_VCS-1:0]        valid,
    input  logic [NUM_VCS*PW-1:0]     port,
    input  logic [NUM_VCS-1:0]        has_ovc,
    input  logic [NUM_VCS-1:0]        credit_ok,
    input  logic [NUM_VCS*TS_W-1:0]   ts,
    input  logic [NUM_PORTS-1:0]      out_free,
    output logic [NUM_VCS-1:0]        elig
);
    logic [PW-1:0] pv;
    logic          ok;
    logic          older;

    always_comb begin
        elig  = '0;
        pv    = '0;
        ok    = 1'b0;
        older = 1'b0;
        for (int v = 0; v < NUM_VCS; v++) begin
            pv    = port[v*PW +: PW];
            ok    = has_ovc[v] ? credit_ok[v] : out_free[pv];
            older = 1'b0;
            for (int u = 0; u < NUM_VCS; u++) begin
                if (u != v && valid[u] && port[u*PW +: PW] == pv &&
                    ts[u*TS_W +: TS_W] < ts[v*TS_W +: TS_W])
                    older = 1'b1;
            end
            elig[v] = valid[v] && ok && !(order_en && older);
        end
    end
endmodule

// File: rtl/sa_switch_alloc.sv
module sa_switch_alloc #(
    parameter int NUM_PORTS = 4,
    parameter int NUM_VCS   = 4,
    parameter int TS_W      = 8,
    localparam int PW = $clog2(NUM_PORTS),
    localparam int VW = $clog2(NUM_VCS),
    localparam int NV = NUM_PORTS * NUM_VCS
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      order_en,
    input  logic [NV-1:0]             req_valid,
    input  logic [NV*PW-1:0]          req_port,
    input  logic [NV-1:0]             req_has_ovc,
    input  logic [NV-1:0]             req_credit_ok,
    input  logic [NV-1:0]             req_tail,
    input  logic [NV*TS_W-1:0]        req_ts,
    input  logic [NUM_PORTS-1:0]      out_free_vc,
    output logic [NUM_PORTS-1:0]      gnt_valid,
    output logic [NUM_PORTS*PW-1:0]   gnt_in,
    output logic [NUM_PORTS*VW-1:0]   gnt_vc,
    output logic [NV-1:0]             vc_gnt,
    output logic [NUM_PORTS-1:0]      ovc_alloc_req,
    output logic [NV-1:0]             credit_ret,
    output logic [NV-1:0]             credit_free
);
    import sa_pkg::*;

    typedef struct packed {
        logic [NUM_PORTS-1:0][VW-1:0] in_ptr;
        logic [NUM_PORTS-1:0][PW-1:0] out_ptr;
    } ptr_state_t;

    ptr_state_t st_d, st_q;

    logic [NUM_PORTS-1:0][NUM_VCS-1:0]   elig;
    logic [NUM_PORTS-1:0]                bid;
    logic [NUM_PORTS-1:0][VW-1:0]        bid_vc;
    logic [NUM_PORTS-1:0][PW-1:0]        bid_port;
    logic [NUM_PORTS-1:0][NUM_PORTS-1:0] req_mx;   // [output][input]
    logic [NUM_PORTS-1:0]                og_valid;
    logic [NUM_PORTS-1:0][PW-1:0]        og_in;

    // Stage one: one VC per input.
    for (genvar gi = 0; gi < NUM_PORTS; gi++) begin : g_in
        sa_vc_filter #(
            .NUM_PORTS(NUM_PORTS), .NUM_VCS(NUM_VCS), .TS_W(TS_W)
        ) u_filt (
            .order_en  (order_en),
            .valid     (req_valid    [gi*NUM_VCS +: NUM_VCS]),
            .port      (req_port     [gi*NUM_VCS*PW +: NUM_VCS*PW]),
            .has_ovc   (req_has_ovc  [gi*NUM_VCS +: NUM_VCS]),
            .credit_ok (req_credit_ok[gi*NUM_VCS +: NUM_VCS]),
            .ts        (req_ts       [gi*NUM_VCS*TS_W +: NUM_VCS*TS_W]),
            .out_free  (out_free_vc),
            .elig      (elig[gi])
        );
        sa_rr_pick #(.W(NUM_VCS)) u_s1 (
            .req   (elig[gi]),
            .ptr   (st_q.in_ptr[gi]),
            .found (bid[gi]),
            .idx   (bid_vc[gi])
        );
        assign bid_port[gi] = req_port[(gi*NUM_VCS + int'(bid_vc[gi]))*PW +: PW];
    end

    // Request matrix built from stage-one winners.
    always_comb begin
        for (int o = 0; o < NUM_PORTS; o++)
            for (int i = 0; i < NUM_PORTS; i++)
                req_mx[o][i] = bid[i] && (bid_port[i] == PW'(o));
    end

    // Stage two: one input per output.
    for (genvar go = 0; go < NUM_PORTS; go++) begin : g_out
        sa_rr_pick #(.W(NUM_PORTS)) u_s2 (
            .req   (req_mx[go]),
            .ptr   (st_q.out_ptr[go]),
            .found (og_valid[go]),
            .idx   (og_in[go])
        );
    end

    int k;
    always_comb begin
        st_d          = st_q;
        gnt_valid     = '0;
        gnt_in        = '0;
        gnt_vc        = '0;
        vc_gnt        = '0;
        ovc_alloc_req = '0;
        credit_ret    = '0;
        credit_free   = '0;
        k             = 0;
        for (int o = 0; o < NUM_PORTS; o++) begin
            if (og_valid[o]) begin
                k                    = int'(og_in[o]) * NUM_VCS + int'(bid_vc[og_in[o]]);
                gnt_valid[o]         = 1'b1;
                gnt_in[o*PW +: PW]   = og_in[o];
                gnt_vc[o*VW +: VW]   = bid_vc[og_in[o]];
                vc_gnt[k]            = 1'b1;
                credit_ret[k]        = 1'b1;
                credit_free[k]       = req_tail[k];
                ovc_alloc_req[o]     = !req_has_ovc[k];
                st_d.out_ptr[o]      = PW'(wrap_inc(int'(og_in[o]), NUM_PORTS));
            end
        end
        for (int i = 0; i < NUM_PORTS; i++) begin
            if (bid[i])
                st_d.in_ptr[i] = VW'(wrap_inc(int'(bid_vc[i]), NUM_VCS));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/sa_switch_alloc_chk.sv
module sa_switch_alloc_chk #(
    parameter int NUM_PORTS = 4,
    parameter int NUM_VCS   = 4,
    parameter int TS_W      = 8,
    localparam int PW = $clog2(NUM_PORTS),
    localparam int VW = $clog2(NUM_VCS),
    localparam int NV = NUM_PORTS * NUM_VCS
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      order_en,
    input logic [NV-1:0]             req_valid,
    input logic [NV*PW-1:0]          req_port,
    input logic [NV-1:0]             req_has_ovc,
    input logic [NV-1:0]             req_credit_ok,
    input logic [NV-1:0]             req_tail,
    input logic [NV*TS_W-1:0]        req_ts,
    input logic [NUM_PORTS-1:0]      out_free_vc,
    input logic [NUM_PORTS-1:0]      gnt_valid,
    input logic [NUM_PORTS*PW-1:0]   gnt_in,
    input logic [NUM_PORTS*VW-1:0]   gnt_vc,
    input logic [NV-1:0]             vc_gnt,
    input logic [NUM_PORTS-1:0]      ovc_alloc_req,
    input logic [NV-1:0]             credit_ret,
    input logic [NV-1:0]             credit_free
);
    logic [NV-1:0]                    legal;
    logic [NV-1:0]                    in_order;
    logic [NUM_PORTS-1:0][PW:0]       in_hits;
    logic [NUM_PORTS-1:0]             ovc_need;
    int                               base;

    always_comb begin
        legal    = '0;
        in_order = '1;
        in_hits  = '0;
        ovc_need = '0;
        base     = 0;
        for (int k = 0; k < NV; k++) begin
            legal[k] = req_valid[k] &&
                       (req_has_ovc[k] ? req_credit_ok[k]
                                       : out_free_vc[req_port[k*PW +: PW]]);
            base = (k / NUM_VCS) * NUM_VCS;
            for (int u = 0; u < NUM_VCS; u++) begin
                if (base + u != k && req_valid[base+u] &&
                    req_port[(base+u)*PW +: PW] == req_port[k*PW +: PW] &&
                    req_ts[(base+u)*TS_W +: TS_W] < req_ts[k*TS_W +: TS_W])
                    in_order[k] = 1'b0;
            end
        end
        for (int o = 0; o < NUM_PORTS; o++) begin
            if (gnt_valid[o]) begin
                in_hits[gnt_in[o*PW +: PW]] = in_hits[gnt_in[o*PW +: PW]] + 1'b1;
                ovc_need[o] = !req_has_ovc[int'(gnt_in[o*PW +: PW])*NUM_VCS
                                           + int'(gnt_vc[o*VW +: VW])];
            end
        end
    end

    for (genvar gi = 0; gi < NUM_PORTS; gi++) begin : g_in_chk
        p_one_vc_per_input_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(vc_gnt[gi*NUM_VCS +: NUM_VCS]));
        p_one_output_per_input_r5: assert property (@(posedge clk) disable iff (!rst_n)
            in_hits[gi] <= 1);
    end

    for (genvar go = 0; go < NUM_PORTS; go++) begin : g_out_chk
        p_ovc_req_matches_r7: assert property (@(posedge clk) disable iff (!rst_n)
            ovc_alloc_req[go] == ovc_need[go]);
        p_ovc_req_has_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
            ovc_alloc_req[go] |-> out_free_vc[go]);
        p_idle_fields_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !gnt_valid[go] |-> (gnt_in[go*PW +: PW] == '0 && gnt_vc[go*VW +: VW] == '0));
        p_grant_pulse_matches_r9: assert property (@(posedge clk) disable iff (!rst_n)
            gnt_valid[go] |-> vc_gnt[int'(gnt_in[go*PW +: PW])*NUM_VCS
                                     + int'(gnt_vc[go*VW +: VW])]);
    end

    for (genvar gk = 0; gk < NV; gk++) begin : g_vc_chk
        p_grant_is_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
            vc_gnt[gk] |-> legal[gk]);
        p_grant_is_oldest_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (vc_gnt[gk] && order_en) |-> in_order[gk]);
        p_credit_with_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
            credit_ret[gk] == vc_gnt[gk]);
        p_credit_free_tail_r8: assert property (@(posedge clk) disable iff (!rst_n)
            credit_free[gk] == (vc_gnt[gk] && req_tail[gk]));
    end
endmodule

bind sa_switch_alloc sa_switch_alloc_chk #(
    .NUM_PORTS(NUM_PORTS), .NUM_VCS(NUM_VCS), .TS_W(TS_W)
) u_chk (.*);

// File: tb/sa_switch_alloc_tb.sv
module sa_switch_alloc_tb_top;
    localparam int N  = 4;
    localparam int V  = 4;
    localparam int TW = 8;
    localparam int PW = $clog2(N);
    localparam int VW = $clog2(V);
    localparam int NV = N * V;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic order_en;
    logic [NV-1:0]    req_valid, req_has_ovc, req_credit_ok, req_tail;
    logic [NV*PW-1:0] req_port;
    logic [NV*TW-1:0] req_ts;
    logic [N-1:0]     out_free_vc;
    logic [N-1:0]     gnt_valid, ovc_alloc_req;
    logic [N*PW-1:0]  gnt_in;
    logic [N*VW-1:0]  gnt_vc;
    logic [NV-1:0]    vc_gnt, credit_ret, credit_free;

    int checks = 0;
    int errors = 0;
    int m_in_ptr [N];
    int m_out_ptr[N];
    bit done = 0;

    always #5 clk = ~clk;

    sa_switch_alloc #(.NUM_PORTS(N), .NUM_VCS(V), .TS_W(TW)) dut_i (.*);

    task automatic check_eq(input string tag, input string what,
                            input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic clear_all();
        order_en = 0; req_valid = '0; req_has_ovc = '0; req_credit_ok = '0;
        req_tail = '0; req_port = '0; req_ts = '0; out_free_vc = '1;
    endtask

    task automatic set_vc(input int i, input int v, input int port, input bit has,
                          input bit cred, input bit tail, input int ts);
        int k = i * V + v;
        req_valid[k] = 1; req_port[k*PW +: PW] = PW'(port); req_has_ovc[k] = has;
        req_credit_ok[k] = cred; req_tail[k] = tail; req_ts[k*TW +: TW] = TW'(ts);
    endtask

    function automatic bit m_elig(input int k);
        int i = k / V;
        int p = int'(req_port[k*PW +: PW]);
        bit ok;
        if (!req_valid[k]) return 0;
        ok = req_has_ovc[k] ? req_credit_ok[k] : out_free_vc[p];
        if (!ok) return 0;
        if (order_en)
            for (int u = 0; u < V; u++) begin
                int q = i * V + u;
                if (q != k && req_valid[q] && int'(req_port[q*PW +: PW]) == p &&
                    req_ts[q*TW +: TW] < req_ts[k*TW +: TW]) return 0;
            end
        return 1;
    endfunction

    // Compare all outputs against the model, then advance model pointers and clock.
    task automatic step(input string tag);
        int e_bid[N]; int e_vc[N]; int e_port[N]; int e_gi[N];
        logic [N-1:0] e_gv = '0, e_ovc = '0;
        logic [N*PW-1:0] e_in = '0;
        logic [N*VW-1:0] e_vcs = '0;
        logic [NV-1:0] e_vg = '0, e_cf = '0;
        for (int i = 0; i < N; i++) begin
            e_bid[i] = 0; e_vc[i] = 0; e_port[i] = 0;
            for (int j = 0; j < V; j++) begin
                int v = (m_in_ptr[i] + j) % V;
                if (!e_bid[i] && m_elig(i*V+v)) begin
                    e_bid[i] = 1; e_vc[i] = v; e_port[i] = int'(req_port[(i*V+v)*PW +: PW]);
                end
            end
        end
        for (int o = 0; o < N; o++) begin
            e_gi[o] = -1;
            for (int j = 0; j < N; j++) begin
                int i = (m_out_ptr[o] + j) % N;
                if (e_gi[o] < 0 && e_bid[i] && e_port[i] == o) e_gi[o] = i;
            end
            if (e_gi[o] >= 0) begin
                int k = e_gi[o] * V + e_vc[e_gi[o]];
                e_gv[o] = 1; e_in[o*PW +: PW] = PW'(e_gi[o]);
                e_vcs[o*VW +: VW] = VW'(e_vc[e_gi[o]]);
                e_vg[k] = 1; e_cf[k] = req_tail[k]; e_ovc[o] = !req_has_ovc[k];
            end
        end
        check_eq(tag, "gnt_valid", 32'(gnt_valid), 32'(e_gv));
        check_eq(tag, "gnt_in", 32'(gnt_in), 32'(e_in));
        check_eq(tag, "gnt_vc", 32'(gnt_vc), 32'(e_vcs));
        check_eq(tag, "vc_gnt", 32'(vc_gnt), 32'(e_vg));
        check_eq(tag, "credit_ret", 32'(credit_ret), 32'(e_vg));
        check_eq(tag, "credit_free", 32'(credit_free), 32'(e_cf));
        check_eq(tag, "ovc_alloc_req", 32'(ovc_alloc_req), 32'(e_ovc));
        for (int i = 0; i < N; i++) if (e_bid[i]) m_in_ptr[i] = (e_vc[i] + 1) % V;
        for (int o = 0; o < N; o++) if (e_gi[o] >= 0) m_out_ptr[o] = (e_gi[o] + 1) % N;
        @(negedge clk); #1;
    endtask

    task automatic settle(); #2; endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired, run did not finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5A11_0C8));
        clear_all();
        for (int i = 0; i < N; i++) begin m_in_ptr[i] = 0; m_out_ptr[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1; #1;

        // R1: idle after reset
        settle();
        check_eq("R1", "gnt_valid idle", 32'(gnt_valid), 0);
        check_eq("R1", "vc_gnt idle", 32'(vc_gnt), 0);
        step("R1");

        // R3: input 0, all VCs to port 1; pointer rotates 0,1,2,3,0
        for (int v = 0; v < V; v++) set_vc(0, v, 1, 1, 1, 0, v);
        for (int c = 0; c < 5; c++) begin
            settle();
            check_eq("R3", "vc_gnt rotation", 32'(vc_gnt), 32'(1) << (c % V));
            check_eq("R9", "gnt_vc port1", 32'(gnt_vc[1*VW +: VW]), c % V);
            step("R3");
        end
        // R3/R2: no credit -> no bid, pointer (now 1) holds
        req_credit_ok = '0;
        settle();
        check_eq("R2", "no credit no grant", 32'(vc_gnt), 0);
        step("R2");
        clear_all();
        set_vc(0, 0, 1, 1, 1, 0, 0); set_vc(0, 2, 1, 1, 1, 0, 0);
        settle();
        check_eq("R3", "pointer held at 1 picks vc2", 32'(vc_gnt), 32'h4);
        step("R3");
        settle();
        check_eq("R3", "wrap picks vc0", 32'(vc_gnt), 32'h1);
        step("R3");

        // R4: every input vc0 to port 2; grants rotate over inputs
        clear_all();
        for (int i = 0; i < N; i++) set_vc(i, 0, 2, 1, 1, 0, 0);
        for (int c = 0; c < 5; c++) begin
            settle();
            check_eq("R4", "gnt_in port2", 32'(gnt_in[2*PW +: PW]), c % N);
            check_eq("R5", "single grant", $countones(vc_gnt), 1);
            step("R4");
        end

        // R2/R7: VC lacking output VC needs a free VC at its port
        clear_all();
        set_vc(1, 1, 3, 0, 0, 0, 0);
        out_free_vc[3] = 0;
        settle();
        check_eq("R2", "no free vc no grant", 32'(vc_gnt), 0);
        step("R2");
        out_free_vc[3] = 1;
        settle();
        check_eq("R7", "ovc_alloc_req", 32'(ovc_alloc_req), 32'h8);
        check_eq("R2", "grant with free vc", 32'(vc_gnt), 32'(1) << 5);
        step("R7");
        req_has_ovc[5] = 1; req_credit_ok[5] = 0;
        settle();
        check_eq("R2", "held ovc without credit", 32'(vc_gnt), 0);
        check_eq("R7", "no ovc request", 32'(ovc_alloc_req), 0);
        step("R2");

        // R6: ordering on input 2 (pointer at 1)
        clear_all();
        order_en = 1;
        set_vc(2, 0, 0, 1, 1, 0, 5); set_vc(2, 1, 0, 1, 1, 0, 20);
        settle();
        check_eq("R6", "older vc0 wins", 32'(vc_gnt), 32'(1) << 8);
        step("R6");
        order_en = 0; req_ts[8*TW +: TW] = 8'd5;
        settle();
        check_eq("R6", "ordering off, pointer picks vc1", 32'(vc_gnt), 32'(1) << 9);
        step("R6");
        order_en = 1; req_ts[8*TW +: TW] = 8'd7; req_ts[9*TW +: TW] = 8'd7;
        settle();
        check_eq("R6", "equal ts, pointer picks vc0", 32'(vc_gnt), 32'(1) << 8);
        step("R6");

        // R8: tail frees the VC
        clear_all();
        set_vc(3, 2, 1, 1, 1, 1, 0);
        settle();
        check_eq("R8", "credit_free tail", 32'(credit_free), 32'(1) << 14);
        check_eq("R8", "credit_ret", 32'(credit_ret), 32'(1) << 14);
        step("R8");
        req_tail[14] = 0;
        settle();
        check_eq("R8", "no free on body", 32'(credit_free), 0);
        step("R8");

        // R10: liveness, one input's VCs on a private output
        begin
            logic [V-1:0] seen = '0;
            clear_all();
            for (int v = 0; v < V; v++) set_vc(1, v, 3, 1, 1, 0, 0);
            for (int c = 0; c < V; c++) begin
                settle(); seen |= vc_gnt[1*V +: V]; step("R10");
            end
            check_eq("R10", "all vcs served", 32'(seen), (1 << V) - 1);
        end
        begin
            logic [N-1:0] seen = '0;
            clear_all();
            for (int i = 0; i < N; i++) set_vc(i, 0, 0, 1, 1, 0, 0);
            for (int c = 0; c < N; c++) begin
                settle();
                if (gnt_valid[0]) seen[gnt_in[0 +: PW]] = 1;
                step("R10");
            end
            check_eq("R10", "all inputs served", 32'(seen), (1 << N) - 1);
        end

        // Random traffic against the model (R2..R9)
        for (int c = 0; c < 3000; c++) begin
            clear_all();
            order_en = ((c / 400) % 2) == 1;
            out_free_vc = N'($urandom);
            for (int k = 0; k < NV; k++)
                if ($urandom_range(9) < 6)
                    set_vc(k / V, k % V, $urandom_range(N-1), $urandom_range(1),
                           $urandom_range(9) < 8, $urandom_range(1), $urandom_range(7));
            settle();
            step("R5");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule